// File: doc/BRIEF.md
# Multicycle Core Sequencing Controller

This block is the control sequencer for a 32-bit multicycle RISC core. The core has one shared instruction/data memory and a single ALU. Each instruction takes several clock cycles. Every instruction starts with a fetch step that also advances the PC by four. Next comes a decode step, which reads the register operands and computes a speculative branch target. After decode, the sequence forks into a short path for the instruction class: memory load, memory store, register-register arithmetic, conditional branch on equality, or unconditional jump. Each path returns to fetch.

The sequencer is a Moore machine. It reads the 6-bit primary opcode from the instruction register and an overflow flag from the ALU, and each cycle it drives all datapath strobes and multiplexer selects as a function of its state alone. Two exception states handle the error cases. An opcode outside the supported set sends the sequencer to one of them. An ALU overflow during register-register execution sends it to the other. Both states record a cause code, store the faulting instruction's address (PC minus 4, computed on the ALU) and load the PC with a fixed handler address.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset puts the sequencer in fetch. Fetch drives memRead=1, irLoad=1, aluASel=0 (PC), aluBSel=01 (constant 4), aluOpSel=00 (add), pcSrcSel=00 (ALU result) and pcLoad=1, with every other strobe at 0.
- R2: The cycle after fetch is always decode. Decode drives aluASel=0, aluBSel=11 (shifted immediate) and aluOpSel=00, and asserts no write or memory strobe.
- R3: Opcode 0x23 (load) runs through three states after decode. The first is address compute (aluASel=1, aluBSel=10 for the sign-extended immediate, aluOpSel=00). The second is memory read (memRead=1, addrFromAlu=1). The third is write-back (regWrite=1, wbFromMem=1, dstFromRd=0). It then returns to fetch.
- R4: Opcode 0x2B (store) runs through address compute and then memory write (memWrite=1, addrFromAlu=1), and then returns to fetch.
- R5: Opcode 0x00 (register-register) runs through execute and then write-back, then returns to fetch. Execute drives aluASel=1, aluBSel=00 (register B) and aluOpSel=10 (function field). Write-back drives regWrite=1, dstFromRd=1 and wbFromMem=0.
- R6: Opcode 0x04 (branch on equal) runs through a single branch state, then returns to fetch. The branch state drives aluASel=1, aluBSel=00, aluOpSel=01 (subtract), pcSrcSel=01 (ALUOut) and pcLoadIfZero=1, with pcLoad=0.
- R7: Opcode 0x02 (jump) runs through a single jump state with pcLoad=1 and pcSrcSel=10 (jump target), then returns to fetch.
- R8: Any other opcode leads from decode to an exception state, then back to fetch. This state drives epcLoad=1, causeLoad=1, causeCode=0, pcLoad=1, pcSrcSel=11 (handler) and the ALU set to PC minus 4 (aluASel=0, aluBSel=01, aluOpSel=01).
- R9: If aluOverflow is high in the execute state, the sequencer skips write-back and goes to an exception state. That state matches the one in R8 except that causeCode=1.
- R10: No cycle asserts both memRead and memWrite.
- R11: aluOverflow has no effect in any state other than execute.
- R12: A reset asserted in the middle of an instruction returns the sequencer to fetch on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Primary opcode from the instruction register |
| aluOverflow | input | 1 | ALU signed-overflow flag |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| addrFromAlu | output | 1 | Memory address source: 0 PC, 1 ALUOut |
| irLoad | output | 1 | Instruction register load |
| dstFromRd | output | 1 | Destination register field: 0 rt, 1 rd |
| wbFromMem | output | 1 | Write-back data: 0 ALUOut, 1 memory data register |
| regWrite | output | 1 | Register file write |
| aluASel | output | 1 | ALU A input: 0 PC, 1 register A |
| aluBSel | output | 2 | ALU B input: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| aluOpSel | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| pcSrcSel | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target, 11 handler |
| pcLoad | output | 1 | Unconditional PC write |
| pcLoadIfZero | output | 1 | PC write gated by ALU zero |
| epcLoad | output | 1 | Exception PC register load |
| causeLoad | output | 1 | Cause register load |
| causeCode | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
The overflow exception is the hardest path to reach. It needs a register-register opcode, and the flag must be present exactly in the execute cycle, after fetch and decode have gone by. The bench sweeps all 64 opcodes twice: once with the flag low and once with it held high for the whole instruction. The second pass reaches the overflow path for opcode 0x00. It also shows that the flag changes no other path: every other opcode must produce the same strobe sequence in both passes. A reset pulse in the middle of a load checks that the sequencer can be pulled back to fetch from inside a path.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MEMRD   = 4'd3,
    ST_LDWB    = 4'd4,
    ST_MEMWR   = 4'd5,
    ST_EXEC    = 4'd6,
    ST_ALUWB   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9,
    ST_EXC_UND = 4'd10,
    ST_EXC_OVF = 4'd11
  } seqState_t;

  // ALU B input selects
  localparam logic [1:0] B_REG   = 2'b00;
  localparam logic [1:0] B_FOUR  = 2'b01;
  localparam logic [1:0] B_IMM   = 2'b10;
  localparam logic [1:0] B_SHIMM = 2'b11;

  // ALU operation selects
  localparam logic [1:0] OP_ADD  = 2'b00;
  localparam logic [1:0] OP_SUB  = 2'b01;
  localparam logic [1:0] OP_FUNC = 2'b10;

  // PC source selects
  localparam logic [1:0] PC_ALU     = 2'b00;
  localparam logic [1:0] PC_ALUOUT  = 2'b01;
  localparam logic [1:0] PC_JUMP    = 2'b10;
  localparam logic [1:0] PC_HANDLER = 2'b11;

  typedef struct packed {
    logic       memRead;
    logic       memWrite;
    logic       addrFromAlu;
    logic       irLoad;
    logic       dstFromRd;
    logic       wbFromMem;
    logic       regWrite;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic [1:0] aluOpSel;
    logic [1:0] pcSrcSel;
    logic       pcLoad;
    logic       pcLoadIfZero;
    logic       epcLoad;
    logic       causeLoad;
    logic       causeCode;
  } strobes_t;

endpackage

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OPC_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OPC_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OPC_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OPC_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OPC_JUMP  = 6'h02
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            aluOverflow,
  output seqState_t       state
);

  seqState_t nextState;
  seqState_t decodeTarget;

  // Dispatch after decode
  always_comb begin
    if (opcode == OPC_LOAD || opcode == OPC_STORE) decodeTarget = ST_ADDR;
    else if (opcode == OPC_RTYPE)                  decodeTarget = ST_EXEC;
    else if (opcode == OPC_BEQ)                    decodeTarget = ST_BRANCH;
    else if (opcode == OPC_JUMP)                   decodeTarget = ST_JUMP;
    else                                           decodeTarget = ST_EXC_UND;
  end

  always_comb begin
    nextState = ST_FETCH;
    unique case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: nextState = decodeTarget;
      ST_ADDR:   nextState = (opcode == OPC_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  nextState = ST_LDWB;
      ST_EXEC:   nextState = aluOverflow ? ST_EXC_OVF : ST_ALUWB;
      ST_LDWB, ST_MEMWR, ST_ALUWB, ST_BRANCH, ST_JUMP,
      ST_EXC_UND, ST_EXC_OVF: nextState = ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  // Requirement R2: decode always follows fetch
  p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));

  // Requirement R9: the overflow exception is entered only from execute with the flag up
  p_ovf_entry_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXC_OVF) |-> ($past(state) == ST_EXEC && $past(aluOverflow)));

  // Requirement R3: memory read only after address compute of a load
  p_read_after_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MEMRD) |-> ($past(state) == ST_ADDR && $past(opcode) == OPC_LOAD));

endmodule

// File: rtl/mc_ctrl_strobes.sv
module mc_ctrl_strobes
  import mc_ctrl_pkg::*;
(
  input  seqState_t state,
  output strobes_t  strobes
);

  always_comb begin
    strobes = '0;
    unique case (state)
      ST_FETCH: begin
        strobes.memRead  = 1'b1;
        strobes.irLoad   = 1'b1;
        strobes.aluBSel  = B_FOUR;
        strobes.aluOpSel = OP_ADD;
        strobes.pcSrcSel = PC_ALU;
        strobes.pcLoad   = 1'b1;
      end
      ST_DECODE: begin
        strobes.aluBSel  = B_SHIMM;
        strobes.aluOpSel = OP_ADD;
      end
      ST_ADDR: begin
        strobes.aluASel  = 1'b1;
        strobes.aluBSel  = B_IMM;
        strobes.aluOpSel = OP_ADD;
      end
      ST_MEMRD: begin
        strobes.memRead     = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite  = 1'b1;
        strobes.wbFromMem = 1'b1;
      end
      ST_MEMWR: begin
        strobes.memWrite    = 1'b1;
        strobes.addrFromAlu = 1'b1;
      end
      ST_EXEC: begin
        strobes.aluASel  = 1'b1;
        strobes.aluBSel  = B_REG;
        strobes.aluOpSel = OP_FUNC;
      end
      ST_ALUWB: begin
        strobes.regWrite  = 1'b1;
        strobes.dstFromRd = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluASel      = 1'b1;
        strobes.aluBSel      = B_REG;
        strobes.aluOpSel     = OP_SUB;
        strobes.pcSrcSel     = PC_ALUOUT;
        strobes.pcLoadIfZero = 1'b1;
      end
      ST_JUMP: begin
        strobes.pcSrcSel = PC_JUMP;
        strobes.pcLoad   = 1'b1;
      end
      ST_EXC_UND, ST_EXC_OVF: begin
        strobes.aluBSel   = B_FOUR;
        strobes.aluOpSel  = OP_SUB;
        strobes.pcSrcSel  = PC_HANDLER;
        strobes.pcLoad    = 1'b1;
        strobes.epcLoad   = 1'b1;
        strobes.causeLoad = 1'b1;
        strobes.causeCode = (state == ST_EXC_OVF);
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            aluOverflow,
  output logic            memRead,
  output logic            memWrite,
  output logic            addrFromAlu,
  output logic            irLoad,
  output logic            dstFromRd,
  output logic            wbFromMem,
  output logic            regWrite,
  output logic            aluASel,
  output logic [1:0]      aluBSel,
  output logic [1:0]      aluOpSel,
  output logic [1:0]      pcSrcSel,
  output logic            pcLoad,
  output logic            pcLoadIfZero,
  output logic            epcLoad,
  output logic            causeLoad,
  output logic            causeCode
);

  seqState_t seqState;
  strobes_t  ctl;

  mc_ctrl_seq #(.OP_W(OP_W)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .aluOverflow(aluOverflow),
    .state      (seqState)
  );

  mc_ctrl_strobes i_strobes (
    .state  (seqState),
    .strobes(ctl)
  );

  assign memRead      = ctl.memRead;
  assign memWrite     = ctl.memWrite;
  assign addrFromAlu  = ctl.addrFromAlu;
  assign irLoad       = ctl.irLoad;
  assign dstFromRd    = ctl.dstFromRd;
  assign wbFromMem    = ctl.wbFromMem;
  assign regWrite     = ctl.regWrite;
  assign aluASel      = ctl.aluASel;
  assign aluBSel      = ctl.aluBSel;
  assign aluOpSel     = ctl.aluOpSel;
  assign pcSrcSel     = ctl.pcSrcSel;
  assign pcLoad       = ctl.pcLoad;
  assign pcLoadIfZero = ctl.pcLoadIfZero;
  assign epcLoad      = ctl.epcLoad;
  assign causeLoad    = ctl.causeLoad;
  assign causeCode    = ctl.causeCode;

  // Requirement R1: first cycle out of reset is a fetch
  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irLoad && memRead && pcLoad));

  // Requirement R4: a store writes memory at ALUOut computed from register plus immediate
  p_store_addr_r4: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> (addrFromAlu && $past(aluASel) && $past(aluBSel) == B_IMM));

  // Requirement R5: ALU write-back only after a function-field operation without overflow
  p_aluwb_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (regWrite && dstFromRd) |-> ($past(aluOpSel) == OP_FUNC && !$past(aluOverflow)));

  // Requirement R6: a conditional branch returns straight to fetch
  p_branch_return_r6: assert property (@(posedge clk) disable iff (rst)
    pcLoadIfZero |=> irLoad);

  // Requirement R7: a jump returns straight to fetch
  p_jump_return_r7: assert property (@(posedge clk) disable iff (rst)
    (pcLoad && pcSrcSel == PC_JUMP) |=> irLoad);

  // Requirement R8: undefined opcode trap comes right after decode and returns to fetch
  p_undef_from_decode_r8: assert property (@(posedge clk) disable iff (rst)
    (causeLoad && !causeCode) |-> ($past(aluBSel) == B_SHIMM));
  p_exc_return_r8: assert property (@(posedge clk) disable iff (rst)
    epcLoad |=> irLoad);

  // Requirement R10: one memory access per cycle
  p_one_mem_r10: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

endmodule

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mc_ctrl_fsm;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic aluOverflow = 1'b0;
  logic memRead, memWrite, addrFromAlu, irLoad, dstFromRd, wbFromMem, regWrite, aluASel;
  logic [1:0] aluBSel, aluOpSel, pcSrcSel;
  logic pcLoad, pcLoadIfZero, epcLoad, causeLoad, causeCode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode), .aluOverflow(aluOverflow),
    .memRead(memRead), .memWrite(memWrite), .addrFromAlu(addrFromAlu),
    .irLoad(irLoad), .dstFromRd(dstFromRd), .wbFromMem(wbFromMem),
    .regWrite(regWrite), .aluASel(aluASel), .aluBSel(aluBSel),
    .aluOpSel(aluOpSel), .pcSrcSel(pcSrcSel), .pcLoad(pcLoad),
    .pcLoadIfZero(pcLoadIfZero), .epcLoad(epcLoad), .causeLoad(causeLoad),
    .causeCode(causeCode)
  );

  // Step codes used by the bench
  localparam int S_F = 0, S_D = 1, S_A = 2, S_MR = 3, S_LW = 4, S_MW = 5,
                 S_EX = 6, S_RW = 7, S_BR = 8, S_J = 9, S_XU = 10, S_XO = 11;

  // Expected output vector per step, written from the requirement text
  function automatic logic [18:0] expect_of(int s);
    // {memRead,memWrite,addrFromAlu,irLoad,dstFromRd,wbFromMem,regWrite,aluASel,
    //  aluBSel,aluOpSel,pcSrcSel,pcLoad,pcLoadIfZero,epcLoad,causeLoad,causeCode}
    case (s)
      S_F:  return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0};
      S_D:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_A:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_MR: return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_LW: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_MW: return {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_EX: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_RW: return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0};
      S_BR: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b01,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0};
      S_J:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b1,1'b0,1'b0,1'b0,1'b0};
      S_XU: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,2'b11,1'b1,1'b0,1'b1,1'b1,1'b0};
      default: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,2'b11,1'b1,1'b0,1'b1,1'b1,1'b1};
    endcase
  endfunction

  function automatic logic [18:0] actual();
    return {memRead,memWrite,addrFromAlu,irLoad,dstFromRd,wbFromMem,regWrite,aluASel,
            aluBSel,aluOpSel,pcSrcSel,pcLoad,pcLoadIfZero,epcLoad,causeLoad,causeCode};
  endfunction

  task automatic check_step(int s, string req);
    testsRun++;
    if (actual() !== expect_of(s)) begin
      testsFailed++;
      $display("FAIL %s op=%02h ovf=%0b step=%0d actual=%05h expected=%05h",
               req, opcode, aluOverflow, s, actual(), expect_of(s));
    end
    // R10: never read and write memory in one cycle
    testsRun++;
    if (memRead && memWrite) begin
      testsFailed++;
      $display("FAIL R10 actual memRead=1 memWrite=1 expected not both");
    end
  endtask

  // Called at a negedge while the sequencer sits in fetch
  task automatic run_instr(logic [5:0] op, logic ovf);
    int path[4];
    int len;
    string req;
    opcode = op;
    aluOverflow = ovf;
    path[0] = S_D;
    case (op)
      6'h23: begin path[1] = S_A;  path[2] = S_MR; path[3] = S_LW; len = 4; req = "R3"; end
      6'h2B: begin path[1] = S_A;  path[2] = S_MW; len = 3; req = "R4"; end
      6'h00: begin path[1] = S_EX; path[2] = ovf ? S_XO : S_RW; len = 3;
                   req = ovf ? "R9" : "R5"; end
      6'h04: begin path[1] = S_BR; len = 2; req = "R6"; end
      6'h02: begin path[1] = S_J;  len = 2; req = "R7"; end
      default: begin path[1] = S_XU; len = 2; req = "R8"; end
    endcase
    // R11: with the flag held high, non-execute paths must be unchanged
    if (ovf && op != 6'h00) req = {req, "/R11"};
    check_step(S_F, "R1");
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      check_step(path[k], (k == 0) ? "R2" : req);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset is fetch
    check_step(S_F, "R1");

    // Exhaustive sweep of opcodes, flag low then held high
    for (int pass = 0; pass < 2; pass++) begin
      for (int op = 0; op < 64; op++) begin
        run_instr(op[5:0], pass[0]);
      end
    end

    // R12: reset in the middle of a load
    opcode = 6'h23;
    aluOverflow = 1'b0;
    @(negedge clk);          // decode
    check_step(S_D, "R12");
    @(negedge clk);          // address compute
    check_step(S_A, "R12");
    rst = 1'b1;
    @(negedge clk);
    check_step(S_F, "R12");
    rst = 1'b0;
    // a full instruction after the abort
    run_instr(6'h2B, 1'b0);
    run_instr(6'h00, 1'b1);
    run_instr(6'h00, 1'b0);
    check_step(S_F, "R1");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule